// File: doc/BRIEF.md
# Programmable Interrupt Routing Matrix

This block sits between four on-chip peripheral ports (two serial, two parallel) and four shared interrupt pins that leave the chip toward the system interrupt controller, named here by the interrupt lines they normally serve: line 3, line 4, line 5 and line 7. An 8-bit routing byte holds one 2-bit source field per pin. Each pin's field picks which port's request it carries, or leaves the pin undriven. Each pin has its own table of legal sources.

Every pin also has a polarity bit. Before a request reaches the routing, it is masked by that port's enable state, so a port that is switched off or powered down cannot interrupt. The outputs are registered. Each pin presents a level and an output enable for its pad driver, both one clock after the inputs that produce them.

The usual power-on map is routing byte 8'hE2. With that value, line 3 carries the secondary serial port, line 4 the primary serial port, line 5 the primary parallel port, and line 7 is undriven. The register that holds the byte lives outside this block.

Top module: `irq_route_matrix`

## Requirements
- R1: While rst_n is low, every bit of irq_oe and irq_lvl is 0.
- R2: Pin index 0 (line 3) decodes route[7:6]: 00 and 01 leave it undriven, 10 selects the primary serial port (index 0) and 11 selects the secondary serial port (index 1).
- R3: Pin index 1 (line 4) decodes route[5:4] with the same table as line 3.
- R4: Pin index 3 (line 7) decodes route[3:2]: 00 leaves it undriven, 01 selects the primary serial port, 10 the primary parallel port (index 0) and 11 the secondary parallel port (index 1).
- R5: Pin index 2 (line 5) decodes route[1:0]: 00 leaves it undriven, 01 selects the secondary serial port, 10 the primary parallel port and 11 the secondary parallel port.
- R6: pin_pol[i]=1 makes pin i active high: it drives 1 while its selected request is asserted and 0 otherwise. pin_pol[i]=0 makes it active low: it drives 0 while the request is asserted and 1 otherwise.
- R7: A request from a port whose enable bit (ser_on or par_on) is 0 is treated as inactive, so a driven pin routed to that port shows its inactive level.
- R8: A pin with no selected source has irq_oe low and irq_lvl low.
- R9: irq_oe and irq_lvl change exactly one clock edge after the request, enable, routing or polarity input that causes the change, and not before that edge.
- R10: All four pins are decoded independently. One port may drive several pins at the same time, each with its own polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_req | input | 2 | Active-high requests: [0] primary serial, [1] secondary serial |
| par_req | input | 2 | Active-high requests: [0] primary parallel, [1] secondary parallel |
| ser_on | input | 2 | Serial port enabled and powered, per port |
| par_on | input | 2 | Parallel port enabled and powered, per port |
| route | input | 8 | Source fields: [7:6] line 3, [5:4] line 4, [3:2] line 7, [1:0] line 5 |
| pin_pol | input | 4 | Polarity per pin, 1 = active high: [0] line 3, [1] line 4, [2] line 5, [3] line 7 |
| irq_lvl | output | 4 | Registered pin levels, same indexing as pin_pol |
| irq_oe | output | 4 | Registered output enables, same indexing as pin_pol |

## Verification
The block has no parameters. The bench therefore builds it at its only configuration, where all four pins and all four sources exist, and it can sweep the entire input space of every pin. Directed phases step each source field through all four codes while toggling every request, under both polarities. Further phases disable ports and check a tick edge by edge. A long stretch of random routing, enable, polarity and request patterns then compares both output vectors against a behavioural model on every clock.

// File: rtl/irq_route_matrix.sv
module irq_route_matrix (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ser_req,
  input  logic [1:0] par_req,
  input  logic [1:0] ser_on,
  input  logic [1:0] par_on,
  input  logic [7:0] route,
  input  logic [3:0] pin_pol,
  output logic [3:0] irq_lvl,
  output logic [3:0] irq_oe
);

  localparam int PIN_L3 = 0;
  localparam int PIN_L4 = 1;
  localparam int PIN_L5 = 2;
  localparam int PIN_L7 = 3;

  wire [1:0] sq = ser_req & ser_on;
  wire [1:0] pq = par_req & par_on;

  wire [1:0] f_l3 = route[7:6];
  wire [1:0] f_l4 = route[5:4];
  wire [1:0] f_l7 = route[3:2];
  wire [1:0] f_l5 = route[1:0];

  logic [3:0] drv, act;

  always_comb begin
    drv = '0;
    act = '0;

    drv[PIN_L3] = f_l3[1];
    act[PIN_L3] = f_l3[1] & (f_l3[0] ? sq[1] : sq[0]);

    drv[PIN_L4] = f_l4[1];
    act[PIN_L4] = f_l4[1] & (f_l4[0] ? sq[1] : sq[0]);

    drv[PIN_L7] = |f_l7;
    unique case (f_l7)
      2'b01:   act[PIN_L7] = sq[0];
      2'b10:   act[PIN_L7] = pq[0];
      2'b11:   act[PIN_L7] = pq[1];
      default: act[PIN_L7] = 1'b0;
    endcase

    drv[PIN_L5] = |f_l5;
    unique case (f_l5)
      2'b01:   act[PIN_L5] = sq[1];
      2'b10:   act[PIN_L5] = pq[0];
      2'b11:   act[PIN_L5] = pq[1];
      default: act[PIN_L5] = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_oe  <= '0;
      irq_lvl <= '0;
    end else begin
      irq_oe  <= drv;
      irq_lvl <= drv & ~(act ^ pin_pol);
    end
  end

endmodule

// File: rtl/irq_route_matrix_chk.sv
module irq_route_matrix_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ser_on,
  input logic [1:0] par_on,
  input logic [7:0] route,
  input logic [3:0] pin_pol,
  input logic [3:0] irq_lvl,
  input logic [3:0] irq_oe
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl & ~irq_oe) == 4'b0000); // R8

  AST_L3_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> irq_oe[0] == $past(route[7])); // R2

  AST_L4_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> irq_oe[1] == $past(route[5])); // R3

  AST_L7_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> irq_oe[3] == ($past(route[3:2]) != 2'b00)); // R4

  AST_L5_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> irq_oe[2] == ($past(route[1:0]) != 2'b00)); // R5

  AST_OFF_PORTS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(ser_on == 2'b00 && par_on == 2'b00)
      |-> ((irq_lvl ^ ~$past(pin_pol)) & irq_oe) == 4'b0000); // R7

endmodule

bind irq_route_matrix irq_route_matrix_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ser_on(ser_on), .par_on(par_on),
  .route(route), .pin_pol(pin_pol), .irq_lvl(irq_lvl), .irq_oe(irq_oe)
);

// File: tb/irq_route_matrix_tb.sv
module irq_route_matrix_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [1:0] ser_req, par_req, ser_on, par_on;
  logic [7:0] route;
  logic [3:0] pin_pol;
  logic [3:0] irq_lvl, irq_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string tag = "R1";

  irq_route_matrix dut_i (
    .clk(clk), .rst_n(rst_n), .ser_req(ser_req), .par_req(par_req),
    .ser_on(ser_on), .par_on(par_on), .route(route), .pin_pol(pin_pol),
    .irq_lvl(irq_lvl), .irq_oe(irq_oe)
  );

  // Behavioural reference: which request each pin sees, by pin table
  function automatic void model(output logic [3:0] e_oe, output logic [3:0] e_lvl);
    int src;
    bit a;
    for (int p = 0; p < 4; p++) begin
      int code;
      case (p)
        0: code = route[7:6];
        1: code = route[5:4];
        2: code = route[1:0];
        default: code = route[3:2];
      endcase
      src = -1;
      if (p < 2) begin
        if (code == 2) src = 0;
        else if (code == 3) src = 1;
      end else if (p == 2) begin
        if (code == 1) src = 1;
        else if (code == 2) src = 2;
        else if (code == 3) src = 3;
      end else begin
        if (code == 1) src = 0;
        else if (code == 2) src = 2;
        else if (code == 3) src = 3;
      end
      if (src < 0) begin
        e_oe[p] = 1'b0; e_lvl[p] = 1'b0;
      end else begin
        if (src < 2) a = ser_req[src] && ser_on[src];
        else         a = par_req[src-2] && par_on[src-2];
        e_oe[p]  = 1'b1;
        e_lvl[p] = pin_pol[p] ? a : !a;
      end
    end
  endfunction

  task automatic compare(input logic [3:0] e_oe, input logic [3:0] e_lvl);
    checks++;
    if (irq_oe !== e_oe || irq_lvl !== e_lvl) begin
      fails++;
      $display("FAIL %s: oe=%b lvl=%b expected oe=%b lvl=%b (route=%h pol=%b)",
               tag, irq_oe, irq_lvl, e_oe, e_lvl, route, pin_pol);
    end
  endtask

  // Inputs set before tick are taken at the next rising edge and checked at the falling edge
  task automatic tick();
    logic [3:0] eo, el;
    @(negedge clk);
    model(eo, el);
    compare(eo, el);
  endtask

  task automatic sweep_field(input int lo);
    for (int c = 0; c < 4; c++) begin
      route[lo +: 2] = 2'(c);
      for (int r = 0; r < 16; r++) begin
        {ser_req, par_req} = 4'(r);
        tick();
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    ser_req = 2'b11; par_req = 2'b11; ser_on = 2'b11; par_on = 2'b11;
    route = 8'hFF; pin_pol = 4'b1111;
    tag = "R1";
    repeat (3) begin
      @(negedge clk);
      compare(4'b0000, 4'b0000);
    end
    rst_n = 1'b1;

    route = 8'h00; pin_pol = 4'b1111;
    tag = "R8";
    tick(); tick();

    tag = "R2"; route = 8'h00; sweep_field(6);
    tag = "R3"; route = 8'h00; sweep_field(4);
    tag = "R4"; route = 8'h00; sweep_field(2);
    tag = "R5"; route = 8'h00; sweep_field(0);

    tag = "R6";
    route = 8'hBB;
    for (int pp = 0; pp < 16; pp++) begin
      pin_pol = 4'(pp);
      for (int r = 0; r < 16; r++) begin
        {ser_req, par_req} = 4'(r);
        tick();
      end
    end

    tag = "R7";
    ser_req = 2'b11; par_req = 2'b11; pin_pol = 4'b1010;
    for (int rt = 0; rt < 4; rt++) begin
      route = (rt == 0) ? 8'hE2 : (rt == 1) ? 8'hB7 : (rt == 2) ? 8'hEF : 8'hAB;
      for (int en = 0; en < 16; en++) begin
        {ser_on, par_on} = 4'(en);
        tick();
      end
    end

    tag = "R9";
    ser_on = 2'b11; par_on = 2'b11; route = 8'hE2; pin_pol = 4'b1111;
    ser_req = 2'b00; par_req = 2'b00;
    tick();
    ser_req = 2'b10;
    #3;
    checks++;
    if (irq_lvl !== 4'b0000) begin
      fails++;
      $display("FAIL R9: lvl=%b before edge, expected 0000", irq_lvl);
    end
    tick();

    tag = "R10";
    ser_on = 2'b11; par_on = 2'b11;
    route = 8'hAE; pin_pol = 4'b0101;
    ser_req = 2'b01; par_req = 2'b00;
    tick();
    for (int k = 0; k < 3000; k++) begin
      route   = 8'($urandom);
      pin_pol = 4'($urandom);
      ser_req = 2'($urandom); par_req = 2'($urandom);
      ser_on  = 2'($urandom | $urandom);
      par_on  = 2'($urandom | $urandom);
      tick();
    end

    tag = "R1";
    #2 rst_n = 1'b0;
    @(negedge clk);
    compare(4'b0000, 4'b0000);
    rst_n = 1'b1;

    finish_run();
  end
endmodule